// File: doc/BRIEF.md
# Multi-Event Pre-Trigger Sample Buffer

This block sits behind a single ADC channel that delivers one 14-bit sample every clock at 100 MHz. It records the stream into an on-chip sample memory that is cut into equal event slots. When a trigger arrives, it keeps a window the size of one slot. The window holds a programmable number of samples from before the trigger, then the trigger sample and the samples after it. Finished events queue up in slot order, so several can be held before software reads any of them.

A mode input picks the partition of the same memory: a few long slots or many short ones. With the default parameters this is 4 slots of 64 samples or 16 slots of 16 samples, out of 256 locations. The memory scales through `TOTAL_W`.

Readout is a show-ahead word port. `rd_data_o` always shows the current word of the oldest stored event, and each `rd_i` strobe moves to the next word. Every event starts with a header word, followed by its samples in time order. A slot returns to the free pool once its last word has been popped.

Top module: `pretrig_evbuf`

## Requirements
- R1: After reset, `empty_o` is 1, `evt_cnt_o` is 0, `lost_cnt_o` is 0, and the long partition is selected.
- R2: A stored event reads out as one header word followed by L sample words, where L is the slot length. The samples come in time order, sit in bits 13:0, and bits 31:14 are zero. An event counts as stored in the cycle after its last sample is written.
- R3: With an effective pre-trigger length P, the samples are the P samples before the trigger cycle, then the trigger-cycle sample, then the next L-P-1 samples. P is taken in the trigger cycle. With P = L-1 the event completes on the trigger cycle itself.
- R4: Events are buffered up to the number of slots before any readout, and `evt_cnt_o` equals the number stored.
- R5: A trigger that arrives while every slot holds an event, and no capture is in progress, is dropped. `lost_cnt_o` then rises by one, saturating at its maximum.
- R6: The header word holds the event number in bits 31:16 and the clock-cycle timestamp of the trigger cycle in bits 15:0. Event numbers start at 0 after reset and rise by one per stored event.
- R7: Each `rd_i` pops one word. Popping the final word of an event frees its slot and decrements `evt_cnt_o`. `empty_o` is 1 exactly when no event is stored, and `rd_i` has no effect while `empty_o` is 1.
- R8: When `long_mode_i` is 1, the memory holds 4 slots of 64 samples; when it is 0, it holds 16 slots of 16 samples. A requested pre-trigger length above L-1 is clamped to L-1.
- R9: A change of `long_mode_i` takes effect only in a cycle with no stored event and no capture in progress. Until then the previous partition stays in force.
- R10: A trigger is accepted only if the active slot has received at least P samples since it opened. Earlier triggers, and triggers during a capture, are ignored and do not count as lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_mode_i | input | 1 | 1 selects few long slots, 0 selects many short slots |
| pre_len_i | input | 6 | Requested number of pre-trigger samples |
| sample_i | input | 14 | ADC sample for this cycle |
| trig_i | input | 1 | Trigger, sampled every cycle |
| rd_i | input | 1 | Read strobe, pops the shown word |
| rd_data_o | output | 32 | Current readout word (header or sample) |
| empty_o | output | 1 | No stored event |
| evt_cnt_o | output | 5 | Number of stored events |
| lost_cnt_o | output | 16 | Count of triggers dropped for lack of a free slot |

## Verification
The embedded properties take only two things for granted: that reset is asserted once at start-up, and that `trig_i`, `rd_i`, `pre_len_i` and `long_mode_i` may each take any value in any cycle. The stimulus follows those rules, with one deliberate exception. The mode input is flipped while an event is still stored, to show that the partition holds. Between triggers the bench waits longer than a full post-trigger window plus the largest pre-trigger length, so each accepted trigger has a fully primed slot. The one exception is the deliberate early trigger that must be ignored. The pre-trigger length is swept over every value in the short partition, including an out-of-range request, and over the end values and some middle values in the long partition.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TAG_W  = 16;

  typedef struct packed {
    logic [TAG_W-1:0] evt;
    logic [TAG_W-1:0] ts;
  } hdr_t;
endpackage

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned TOTAL_W  = 8,
  parameter int unsigned LONG_W   = 6,
  parameter int unsigned SHORT_W  = 4,
  parameter int unsigned LOST_W   = 16,
  localparam int unsigned IDX_W   = TOTAL_W - SHORT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                long_i,
  input  logic                flush_i,
  input  logic                slot_free_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                trig_i,
  input  logic [LONG_W-1:0]   pre_len_i,
  output logic                wr_en_o,
  output logic [TOTAL_W-1:0]  wr_addr_o,
  output logic [SAMPLE_W-1:0] wr_data_o,
  output logic                busy_o,
  output logic                commit_o,
  output logic [IDX_W-1:0]    commit_slot_o,
  output logic [LONG_W-1:0]   commit_start_o,
  output hdr_t                commit_hdr_o,
  output logic [LOST_W-1:0]   lost_cnt_o
);
  localparam int unsigned N_LONG  = 1 << (TOTAL_W - LONG_W);
  localparam int unsigned N_SHORT = 1 << (TOTAL_W - SHORT_W);

  logic [LONG_W-1:0]  mask, pre_eff, post_m1, wr_off_q, remain_q, start_q, new_start;
  logic [LONG_W:0]    fill_q;
  logic [IDX_W-1:0]   wr_slot_q, slot_last;
  logic [TOTAL_W-1:0] base;
  logic [TAG_W-1:0]   ts_q, evt_q;
  logic [LOST_W-1:0]  lost_q;
  hdr_t               hdr_q;
  logic               post_q, active, accept, finishing, lose;

  always_comb begin
    mask      = long_i ? '1 : LONG_W'((1 << SHORT_W) - 1);
    slot_last = long_i ? IDX_W'(N_LONG - 1) : IDX_W'(N_SHORT - 1);
    pre_eff   = (pre_len_i > mask) ? mask : pre_len_i;
    post_m1   = mask - pre_eff;
    new_start = (wr_off_q - pre_eff) & mask;
    active    = (post_q | slot_free_i) & ~flush_i;
    // enough history in this slot to cover the pre-trigger part
    accept    = active & ~post_q & trig_i & ({1'b0, pre_eff} <= fill_q);
    finishing = active & ((post_q & (remain_q == '0)) | (accept & (post_m1 == '0)));
    lose      = trig_i & ~post_q & ~slot_free_i & ~flush_i;
    base      = long_i ? (TOTAL_W'(wr_slot_q) << LONG_W) : (TOTAL_W'(wr_slot_q) << SHORT_W);
  end

  assign wr_en_o        = active;
  assign wr_addr_o      = base | TOTAL_W'(wr_off_q & mask);
  assign wr_data_o      = sample_i;
  assign busy_o         = post_q;
  assign commit_o       = finishing;
  assign commit_slot_o  = wr_slot_q;
  assign commit_start_o = accept ? new_start : start_q;
  assign commit_hdr_o   = accept ? '{evt: evt_q, ts: ts_q} : hdr_q;
  assign lost_cnt_o     = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_q    <= 1'b0;
      wr_off_q  <= '0;
      remain_q  <= '0;
      start_q   <= '0;
      fill_q    <= '0;
      wr_slot_q <= '0;
      ts_q      <= '0;
      evt_q     <= '0;
      lost_q    <= '0;
      hdr_q     <= '0;
    end else begin
      ts_q <= ts_q + TAG_W'(1);
      if (accept) begin
        evt_q   <= evt_q + TAG_W'(1);
        start_q <= new_start;
        hdr_q   <= '{evt: evt_q, ts: ts_q};
      end
      if (lose && lost_q != '1) lost_q <= lost_q + LOST_W'(1);
      if (flush_i) begin
        post_q    <= 1'b0;
        wr_off_q  <= '0;
        fill_q    <= '0;
        wr_slot_q <= '0;
      end else if (!active) begin
        fill_q <= '0;
      end else begin
        wr_off_q <= (wr_off_q + LONG_W'(1)) & mask;
        if (finishing) begin
          post_q    <= 1'b0;
          fill_q    <= '0;
          wr_slot_q <= (wr_slot_q == slot_last) ? '0 : wr_slot_q + IDX_W'(1);
        end else if (accept) begin
          post_q   <= 1'b1;
          remain_q <= post_m1 - LONG_W'(1);
        end else if (post_q) begin
          remain_q <= remain_q - LONG_W'(1);
        end else if (fill_q <= {1'b0, mask}) begin
          fill_q <= fill_q + (LONG_W+1)'(1);
        end
      end
    end
  end

  AST_LOST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lose && lost_q != '1) |=> (lost_q == $past(lost_q) + LOST_W'(1))); // R5
  AST_FULL_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !slot_free_i && !post_q) |=> $stable(evt_q)); // R5
  AST_EVT_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept) |=> $stable(evt_q)); // R6
  AST_BUSY_IGNORES_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_q && trig_i && !finishing) |=> $stable(start_q)); // R10
endmodule

// File: rtl/pretrig_store.sv
module pretrig_store
  import pbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned TOTAL_W  = 8,
  parameter int unsigned LONG_W   = 6,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                wr_en_i,
  input  logic [TOTAL_W-1:0]  wr_addr_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  input  logic                commit_i,
  input  logic [IDX_W-1:0]    commit_slot_i,
  input  logic [LONG_W-1:0]   commit_start_i,
  input  hdr_t                commit_hdr_i,
  input  logic [TOTAL_W-1:0]  rd_addr_i,
  input  logic [IDX_W-1:0]    rd_slot_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic [LONG_W-1:0]   rd_start_o,
  output hdr_t                rd_hdr_o
);
  localparam int unsigned DEPTH  = 1 << TOTAL_W;
  localparam int unsigned N_SLOT = 1 << IDX_W;

  logic [SAMPLE_W-1:0] mem_q   [DEPTH];
  logic [LONG_W-1:0]   start_q [N_SLOT];
  hdr_t                hdr_q   [N_SLOT];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (commit_i) begin
      start_q[commit_slot_i] <= commit_start_i;
      hdr_q[commit_slot_i]   <= commit_hdr_i;
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign rd_start_o = start_q[rd_slot_i];
  assign rd_hdr_o   = hdr_q[rd_slot_i];
endmodule

// File: rtl/pretrig_readout.sv
module pretrig_readout
  import pbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned TOTAL_W  = 8,
  parameter int unsigned LONG_W   = 6,
  parameter int unsigned SHORT_W  = 4,
  localparam int unsigned IDX_W   = TOTAL_W - SHORT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                long_i,
  input  logic                flush_i,
  input  logic                empty_i,
  input  logic                rd_i,
  input  logic [LONG_W-1:0]   start_i,
  input  hdr_t                hdr_i,
  input  logic [SAMPLE_W-1:0] mem_data_i,
  output logic [TOTAL_W-1:0]  rd_addr_o,
  output logic [IDX_W-1:0]    rd_slot_o,
  output logic                free_o,
  output logic [WORD_W-1:0]   rd_data_o
);
  localparam int unsigned N_LONG  = 1 << (TOTAL_W - LONG_W);
  localparam int unsigned N_SHORT = 1 << (TOTAL_W - SHORT_W);

  logic [LONG_W:0]    idx_q, last_idx;
  logic [LONG_W-1:0]  mask, off;
  logic [IDX_W-1:0]   rd_slot_q, slot_last;
  logic [TOTAL_W-1:0] base;
  logic               pop;

  always_comb begin
    mask      = long_i ? '1 : LONG_W'((1 << SHORT_W) - 1);
    slot_last = long_i ? IDX_W'(N_LONG - 1) : IDX_W'(N_SHORT - 1);
    last_idx  = {1'b0, mask} + (LONG_W+1)'(1);
    pop       = rd_i & ~empty_i;
    // word 0 is the header, word k is sample k-1 counted from the event start
    off       = (start_i + idx_q[LONG_W-1:0] - LONG_W'(1)) & mask;
    base      = long_i ? (TOTAL_W'(rd_slot_q) << LONG_W) : (TOTAL_W'(rd_slot_q) << SHORT_W);
  end

  assign rd_addr_o = base | TOTAL_W'(off);
  assign rd_slot_o = rd_slot_q;
  assign free_o    = pop & (idx_q == last_idx);
  assign rd_data_o = (idx_q == '0) ? WORD_W'(hdr_i) : WORD_W'(mem_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      rd_slot_q <= '0;
    end else if (flush_i) begin
      idx_q     <= '0;
      rd_slot_q <= '0;
    end else if (pop) begin
      if (idx_q == last_idx) begin
        idx_q     <= '0;
        rd_slot_q <= (rd_slot_q == slot_last) ? '0 : rd_slot_q + IDX_W'(1);
      end else begin
        idx_q <= idx_q + (LONG_W+1)'(1);
      end
    end
  end

  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && rd_i && !flush_i) |=> ($stable(rd_slot_q) && $stable(idx_q))); // R7
endmodule

// File: rtl/pretrig_evbuf.sv
module pretrig_evbuf
  import pbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned TOTAL_W  = 8,
  parameter int unsigned LONG_W   = 6,
  parameter int unsigned SHORT_W  = 4,
  parameter int unsigned LOST_W   = 16,
  localparam int unsigned CNT_W   = TOTAL_W - SHORT_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                long_mode_i,
  input  logic [LONG_W-1:0]   pre_len_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                trig_i,
  input  logic                rd_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                empty_o,
  output logic [CNT_W-1:0]    evt_cnt_o,
  output logic [LOST_W-1:0]   lost_cnt_o
);
  localparam int unsigned IDX_W   = TOTAL_W - SHORT_W;
  localparam int unsigned N_LONG  = 1 << (TOTAL_W - LONG_W);
  localparam int unsigned N_SHORT = 1 << (TOTAL_W - SHORT_W);

  logic               mode_q, flush, slot_free, busy, commit, free, wr_en;
  logic [CNT_W-1:0]   cnt_q, n_slots;
  logic [TOTAL_W-1:0] wr_addr, rd_addr;
  logic [SAMPLE_W-1:0] wr_data, mem_data;
  logic [IDX_W-1:0]   commit_slot, rd_slot;
  logic [LONG_W-1:0]  commit_start, rd_start;
  hdr_t               commit_hdr, rd_hdr;

  assign n_slots   = mode_q ? CNT_W'(N_LONG) : CNT_W'(N_SHORT);
  assign slot_free = cnt_q < n_slots;
  assign flush     = (long_mode_i != mode_q) & (cnt_q == '0) & ~busy;
  assign empty_o   = cnt_q == '0;
  assign evt_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      if (flush) mode_q <= long_mode_i;
      cnt_q <= cnt_q + CNT_W'(commit) - CNT_W'(free);
    end
  end

  pretrig_capture #(
    .SAMPLE_W(SAMPLE_W), .TOTAL_W(TOTAL_W), .LONG_W(LONG_W),
    .SHORT_W(SHORT_W), .LOST_W(LOST_W)
  ) u_capture (
    .clk_i, .rst_ni,
    .long_i(mode_q), .flush_i(flush), .slot_free_i(slot_free),
    .sample_i, .trig_i, .pre_len_i,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy),
    .commit_o(commit), .commit_slot_o(commit_slot), .commit_start_o(commit_start),
    .commit_hdr_o(commit_hdr), .lost_cnt_o(lost_cnt_o)
  );

  pretrig_store #(
    .SAMPLE_W(SAMPLE_W), .TOTAL_W(TOTAL_W), .LONG_W(LONG_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .commit_i(commit), .commit_slot_i(commit_slot), .commit_start_i(commit_start),
    .commit_hdr_i(commit_hdr),
    .rd_addr_i(rd_addr), .rd_slot_i(rd_slot),
    .rd_data_o(mem_data), .rd_start_o(rd_start), .rd_hdr_o(rd_hdr)
  );

  pretrig_readout #(
    .SAMPLE_W(SAMPLE_W), .TOTAL_W(TOTAL_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W)
  ) u_readout (
    .clk_i, .rst_ni,
    .long_i(mode_q), .flush_i(flush), .empty_i(empty_o), .rd_i,
    .start_i(rd_start), .hdr_i(rd_hdr), .mem_data_i(mem_data),
    .rd_addr_o(rd_addr), .rd_slot_o(rd_slot), .free_o(free), .rd_data_o
  );

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_slots); // R4
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(mode_q)); // R9
  AST_FREE_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free |-> (cnt_q != '0)); // R7
endmodule

// File: tb/pretrig_evbuf_bench.sv
module pretrig_evbuf_bench;
  localparam int SW = 14, TW = 8, LW = 6, SHW = 4, LOSTW = 16;
  localparam int CW = TW - SHW + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, long_mode_i = 1'b1, trig_i = 1'b0, rd_i = 1'b0;
  logic [LW-1:0] pre_len_i = '0;
  logic [SW-1:0] sample_i = '0;
  logic [31:0] rd_data_o;
  logic empty_o;
  logic [CW-1:0] evt_cnt_o;
  logic [LOSTW-1:0] lost_cnt_o;

  int checks = 0, fails = 0, s_cnt = 0, next_evt = 0, ts_ofs = -1;
  int exp_tv[$], exp_pre[$];
  bit done = 1'b0;

  pretrig_evbuf u_pretrig_evbuf (.*);

  always #5 clk_i = ~clk_i;

  initial forever begin
    @(posedge clk_i); #2;
    sample_i = SW'(s_cnt);
    s_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask

  task automatic fire(input int pre, input int len, input bit stored);
    step();
    pre_len_i = LW'(pre);
    trig_i = 1'b1;
    if (stored) begin
      exp_tv.push_back(int'(sample_i));
      exp_pre.push_back(pre > len - 1 ? len - 1 : pre);
    end
    step();
    trig_i = 1'b0;
  endtask

  task automatic read_events(input int n, input int len);
    for (int e = 0; e < n; e++) begin
      int tv, pre, ex, dts;
      tv = exp_tv.pop_front();
      pre = exp_pre.pop_front();
      rd_i = 1'b1;
      chk(rd_data_o[31:16] == 16'(next_evt), "R6 event number", int'(rd_data_o[31:16]), next_evt);
      dts = (int'(rd_data_o[15:0]) - tv) & 'h3fff;
      if (ts_ofs < 0) ts_ofs = dts;
      else chk(dts == ts_ofs, "R6 timestamp", dts, ts_ofs);
      next_evt++;
      step();
      for (int j = 0; j < len; j++) begin
        ex = (tv - pre + j) & 'h3fff;
        chk(rd_data_o == 32'(ex), "R2 R3 sample window", int'(rd_data_o), ex);
        step();
      end
    end
    rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int pl1[4] = '{0, 1, 37, 63};
    int pl2[4] = '{62, 5, 20, 63};
    step(3);
    rst_ni = 1'b1;
    step();
    chk(empty_o == 1'b1, "R1 empty", empty_o, 1);
    chk(evt_cnt_o == 0, "R1 count", int'(evt_cnt_o), 0);
    chk(lost_cnt_o == 0, "R1 lost", int'(lost_cnt_o), 0);
    step(80);

    // long partition, fill all four slots
    for (int i = 0; i < 4; i++) begin fire(pl1[i], 64, 1'b1); step(130); end
    chk(evt_cnt_o == 4, "R4 four long events", int'(evt_cnt_o), 4);
    chk(empty_o == 1'b0, "R7 not empty", empty_o, 0);
    fire(5, 64, 1'b0);
    step(5);
    chk(lost_cnt_o == 1, "R5 lost on full", int'(lost_cnt_o), 1);
    chk(evt_cnt_o == 4, "R5 count unchanged", int'(evt_cnt_o), 4);
    read_events(4, 64);
    chk(empty_o == 1'b1, "R7 empty after read", empty_o, 1);
    chk(evt_cnt_o == 0, "R7 count after read", int'(evt_cnt_o), 0);
    rd_i = 1'b1; step(5); rd_i = 1'b0;
    chk(empty_o == 1'b1, "R7 read while empty", empty_o, 1);
    chk(evt_cnt_o == 0, "R7 count while empty", int'(evt_cnt_o), 0);

    step(70);
    for (int i = 0; i < 4; i++) begin fire(pl2[i], 64, 1'b1); step(130); end
    chk(evt_cnt_o == 4, "R4 second round", int'(evt_cnt_o), 4);
    read_events(4, 64);

    // arming and completion timing
    step(70);
    fire(0, 64, 1'b1);
    step(62);
    chk(evt_cnt_o == 0, "R2 not stored before last sample", int'(evt_cnt_o), 0);
    step();
    chk(evt_cnt_o == 1, "R2 stored after last sample", int'(evt_cnt_o), 1);
    fire(63, 64, 1'b0);
    step(10);
    chk(evt_cnt_o == 1, "R10 unprimed trigger ignored", int'(evt_cnt_o), 1);
    chk(lost_cnt_o == 1, "R10 not counted lost", int'(lost_cnt_o), 1);
    step(70);
    fire(63, 64, 1'b1);
    chk(evt_cnt_o == 2, "R3 pre L-1 completes at trigger", int'(evt_cnt_o), 2);
    read_events(2, 64);

    // mode change held while an event is stored
    step(70);
    fire(10, 64, 1'b1);
    step(70);
    long_mode_i = 1'b0;
    step(5);
    chk(evt_cnt_o == 1, "R9 event kept", int'(evt_cnt_o), 1);
    read_events(1, 64);
    chk(empty_o == 1'b1, "R9 long event fully read", empty_o, 1);
    step(40);

    // short partition, pre sweep with one clamped request
    for (int k = 0; k < 16; k++) begin
      fire(k < 15 ? k : 40, 16, 1'b1);
      step(40);
    end
    chk(evt_cnt_o == 16, "R8 sixteen short events", int'(evt_cnt_o), 16);
    fire(3, 16, 1'b0);
    step(3);
    chk(lost_cnt_o == 2, "R5 lost in short mode", int'(lost_cnt_o), 2);
    read_events(16, 16);
    chk(empty_o == 1'b1, "R8 empty after short read", empty_o, 1);

    done = 1'b1;
    finish_run();
  end
endmodule